// File: doc/BRIEF.md
# External Bus Suspend-Tristate Controller

This block is the external memory bus master for a processor core. The core starts one read or write at a time by pulsing a request together with an address, write data and a memory-select index. The block then drives the address, the selects, the write data and an active-low read or write strobe. It waits a programmable number of wait states and completes the access when acknowledge is high.

An external device, such as a DRAM controller preparing a page, can raise an asynchronous suspend input to take the bus away. After a two-flop synchronizer, the block floats every bus output on the next cycle, even if an access is partway through. A suspended access is not completed and not dropped. It waits in a held state and reports a halt to the core. When suspend drops, the access starts again from its address phase with a freshly loaded wait-state count. Suspend while the bus is idle only floats the bus. The core is halted only if it then asks for an access.

The controller has four states:
- **IDLE**: no access. Strobes and selects are inactive.
- **ADDR**: address and selects are driven. Strobes are inactive.
- **STRB**: a strobe is asserted and wait states are counted.
- **HELD**: the access is suspended.

The transitions are:

| Name | From | To | Condition |
|---|---|---|---|
| accept | IDLE | ADDR | request, bus not suspended |
| defer | IDLE | HELD | request while suspended |
| strobe | ADDR | STRB | counter loaded |
| stall | ADDR or STRB | HELD | synchronized suspend is high |
| finish | STRB | IDLE | counter zero and acknowledge high |
| resume | HELD | ADDR | synchronized suspend is low |

Top module: `xbus_suspend_ctl`

## Requirements
- R1: `susp_async_i` passes through two flops, then one more register, before it reaches the enables. If `susp_async_i` is high before rising edge k, `bus_oe_o` and `bus_data_oe_o` are low from edge k+2. Release follows the same latency.
- R2: If the synchronized suspend is high while an access is in ADDR or STRB, the access moves to HELD. It does not complete: `done_o` stays low, `rdata_o` is unchanged and `ack_i` is ignored.
- R3: Suspend with no access pending floats the bus and leaves `halt_o` low. A request made while suspended enters HELD and raises `halt_o` on the next cycle.
- R4: HELD leaves one edge after the synchronized suspend falls. In that cycle `halt_o` is low, the bus is driven, the selects are asserted and both strobes are inactive (ADDR). The strobe follows one cycle later.
- R5: The wait counter is loaded from `wait_cfg_i` on every ADDR-to-STRB step. A resumed access with N wait states and acknowledge held high therefore keeps its strobe low for N+1 cycles.
- R6: In STRB the access finishes at the edge where the counter is zero and `ack_i` is high. `done_o` is then high for one cycle. For a read, `rdata_o` holds the `bus_rdata_i` value sampled at that edge.
- R7: If `ack_i` is low once the counter has reached zero, the access stays in STRB with its strobe asserted until `ack_i` is high.
- R8: While `rst_n` is low, the block is IDLE, `done_o` and `halt_o` are low, the strobes are high and `bus_sel_n_o` is all ones. The bus enables still follow suspend as in R1.
- R9: `bus_sel_n_o` is active-low one-hot: bit `req_sel_i` is 0 in ADDR and STRB. In STRB, `bus_rd_n_o` is 0 for a read (`req_we_i`=0) and `bus_wr_n_o` is 0 for a write. `bus_data_oe_o` is high only for a write in ADDR or STRB, and only while the bus is not floated.
- R10: A request is taken only in IDLE. A request made while an access is under way does not change the bus address or the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| susp_async_i | input | 1 | Asynchronous suspend request; high floats the bus |
| req_i | input | 1 | Access request pulse, taken in IDLE |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_sel_i | input | SEL_W | Memory-select index |
| req_wdata_i | input | DATA_W | Write data |
| wait_cfg_i | input | WAIT_W | Wait-state count loaded at each strobe start |
| ack_i | input | 1 | Acknowledge from the memory |
| bus_rdata_i | input | DATA_W | Read data from the bus |
| halt_o | output | 1 | Access held by suspend; the core must stall |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| bus_oe_o | output | 1 | Enable for address, selects and strobes |
| bus_data_oe_o | output | 1 | Enable for write data |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_sel_n_o | output | SEL_N | Active-low memory selects |
| bus_rd_n_o | output | 1 | Active-low read strobe |
| bus_wr_n_o | output | 1 | Active-low write strobe |

## Verification
Plain reads and writes are run with zero and several wait states, and with acknowledge held low. These separate the counting from the acknowledge handling. Suspend is then raised in four situations: while idle, before a request, during the address phase and during the strobe phase. The idle case shows whether halt is raised only for a real access. The two mid-access cases show whether a held access restarts from its address phase with a reloaded count, rather than finishing or resuming partway. Suspend is also raised while reset is held, which checks that the float path does not depend on reset.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        XB_IDLE = 2'd0,
        XB_ADDR = 2'd1,
        XB_STRB = 2'd2,
        XB_HELD = 2'd3
    } xb_state_e;
endpackage

// File: rtl/xbus_sync2.sv
module xbus_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // No reset: the suspend path must work while the controller is in reset.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) chain_q <= d_i;
        end else begin : g_chain
            always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    input  logic              dec_i,
    output logic              zero_o
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/xbus_suspend_ctl.sv
module xbus_suspend_ctl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEL_N  = 4,
    parameter int WAIT_W = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W = (SEL_N > 1) ? $clog2(SEL_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              susp_async_i,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [SEL_W-1:0]  req_sel_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              halt_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              bus_oe_o,
    output logic              bus_data_oe_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic [SEL_N-1:0]  bus_sel_n_o,
    output logic              bus_rd_n_o,
    output logic              bus_wr_n_o
);
    xb_state_e         state_q, state_d;
    logic              susp_s;
    logic              float_q;
    logic              cnt_zero;
    logic              cnt_load;
    logic              cnt_dec;
    logic              finish;
    logic              accept;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic [SEL_N-1:0]  sel_hot;

    xbus_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (susp_async_i),
        .q_o (susp_s)
    );

    // The float register is kept out of reset so that suspend still floats the bus during reset.
    always_ff @(posedge clk) float_q <= susp_s;

    assign cnt_load = (state_q == XB_ADDR) && !susp_s;
    assign cnt_dec  = (state_q == XB_STRB) && !susp_s;
    assign finish   = (state_q == XB_STRB) && !susp_s && cnt_zero && ack_i;
    assign accept   = (state_q == XB_IDLE) && req_i;

    xbus_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (wait_cfg_i),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XB_IDLE: if (req_i) state_d = susp_s ? XB_HELD : XB_ADDR; // defer / accept
            XB_ADDR: state_d = susp_s ? XB_HELD : XB_STRB;            // stall / strobe
            XB_STRB: begin
                if (susp_s)      state_d = XB_HELD;                  // stall
                else if (finish) state_d = XB_IDLE;                  // finish
            end
            XB_HELD: if (!susp_s) state_d = XB_ADDR;                 // resume
            default: state_d = XB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            sel_q   <= '0;
            wd_q    <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                we_q   <= req_we_i;
                addr_q <= req_addr_i;
                sel_q  <= req_sel_i;
                wd_q   <= req_wdata_i;
            end
            if (finish && !we_q) rdata_q <= bus_rdata_i;
        end
    end

    assign sel_hot = {{(SEL_N-1){1'b0}}, 1'b1} << sel_q;

    always_comb begin
        bus_oe_o      = !float_q;
        bus_data_oe_o = 1'b0;
        bus_sel_n_o   = '1;
        bus_rd_n_o    = 1'b1;
        bus_wr_n_o    = 1'b1;
        halt_o        = (state_q == XB_HELD);
        unique case (state_q)
            XB_ADDR: begin
                bus_sel_n_o   = ~sel_hot;
                bus_data_oe_o = we_q && !float_q;
            end
            XB_STRB: begin
                bus_sel_n_o   = ~sel_hot;
                bus_data_oe_o = we_q && !float_q;
                bus_rd_n_o    = we_q;
                bus_wr_n_o    = !we_q;
            end
            default: ;
        endcase
    end

    assign bus_addr_o  = addr_q;
    assign bus_wdata_o = wd_q;
    assign rdata_o     = rdata_q;
    assign done_o      = done_q;

    // R1
    float_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_s) |=> !bus_oe_o);
    // R9
    strobe_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n_o || !bus_wr_n_o) |-> bus_oe_o);
    // R2
    held_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !done_o);
    // R4
    resume_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_o) |-> (bus_rd_n_o && bus_wr_n_o && bus_oe_o));
    // R6
    done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ack_i));
endmodule

// File: tb/xbus_suspend_ctl_tb.sv
module xbus_suspend_ctl_tb_top;
    localparam int CLK_P  = 10;
    localparam int AW     = 16;
    localparam int DW     = 16;
    localparam int NS     = 4;
    localparam int WW     = 4;
    localparam int SW     = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          susp = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [SW-1:0] sel = '0;
    logic [DW-1:0] wd = '0;
    logic [WW-1:0] wcfg = '0;
    logic          ack = 1'b1;
    logic [DW-1:0] brd = 16'h1234;

    logic          halt, done, oe, doe, rd_n, wr_n;
    logic [DW-1:0] rdata, bwd;
    logic [AW-1:0] baddr;
    logic [NS-1:0] seln;

    xbus_suspend_ctl #(.ADDR_W(AW), .DATA_W(DW), .SEL_N(NS), .WAIT_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .susp_async_i(susp), .req_i(req), .req_we_i(we),
        .req_addr_i(addr), .req_sel_i(sel), .req_wdata_i(wd), .wait_cfg_i(wcfg),
        .ack_i(ack), .bus_rdata_i(brd), .halt_o(halt), .done_o(done), .rdata_o(rdata),
        .bus_oe_o(oe), .bus_data_oe_o(doe), .bus_addr_o(baddr), .bus_wdata_o(bwd),
        .bus_sel_n_o(seln), .bus_rd_n_o(rd_n), .bus_wr_n_o(wr_n)
    );

    always #(CLK_P/2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_en = 0;
    bit    finished = 0;
    string scen = "R8 reset";

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", tag, scen, what, act, exp);
        end
    endtask

    // Behavioural reference: the phase is 0 idle, 1 address, 2 strobe, 3 held.
    int            m_ph = 0;
    int            m_wait = 0;
    bit            m_q[$] = '{0, 0};
    bit            m_flt = 0;
    bit            m_we = 0, m_done = 0;
    logic [AW-1:0] m_addr = '0;
    int            m_sel = 0;
    logic [DW-1:0] m_wd = '0, m_rdata = '0;

    always @(posedge clk) begin
        bit s_now;
        s_now = m_q[1];
        m_flt = s_now;
        m_q.pop_back();
        m_q.push_front(susp);
        if (!rst_n) begin
            m_ph = 0; m_wait = 0; m_done = 0; m_rdata = '0;
            m_we = 0; m_addr = '0; m_sel = 0; m_wd = '0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: if (req) begin
                    m_we = we; m_addr = addr; m_sel = int'(sel); m_wd = wd;
                    m_ph = s_now ? 3 : 1;
                end
                1: if (s_now) m_ph = 3; else begin m_ph = 2; m_wait = int'(wcfg); end
                2: if (s_now) m_ph = 3;
                   else if (m_wait == 0 && ack) begin
                       m_ph = 0; m_done = 1;
                       if (!m_we) m_rdata = brd;
                   end else if (m_wait != 0) m_wait--;
                default: if (!s_now) m_ph = 1;
            endcase
        end
        #(CLK_P/4);
        if (cmp_en) begin
            bit act_ph;
            logic [NS-1:0] e_sel;
            act_ph = (m_ph == 1 || m_ph == 2);
            e_sel = act_ph ? ~(NS'(1) << m_sel) : '1;
            chk("R1", "bus_oe", oe, !m_flt);
            chk("R9", "data_oe", doe, !m_flt && m_we && act_ph);
            chk("R9", "rd_n", rd_n, !(m_ph == 2 && !m_we));
            chk("R9", "wr_n", wr_n, !(m_ph == 2 && m_we));
            chk("R9", "sel_n", seln, e_sel);
            chk("R3", "halt", halt, m_ph == 3);
            chk("R6", "done", done, m_done);
            chk("R6", "rdata", rdata, m_rdata);
            if (!m_flt) chk("R10", "addr", baddr, m_addr);
            if (doe) chk("R9", "wdata", bwd, m_wd);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [DW-1:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; sel = s; wd = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        int strb_cnt;
        tick(4);
        cmp_en = 1;
        tick(2);
        chk("R8", "done in reset", done, 0);
        chk("R8", "rd_n in reset", rd_n, 1);
        rst_n = 1'b1;

        scen = "R6 read no wait";
        wcfg = 0; ack = 1; brd = 16'hA5A5;
        issue(0, 16'h0040, 2'd1, 16'h0);
        tick(4);
        chk("R6", "captured read", rdata, 16'hA5A5);

        scen = "R9 write three waits";
        wcfg = 3;
        issue(1, 16'h0188, 2'd2, 16'hBEEF);
        tick(8);

        scen = "R7 ack low";
        wcfg = 1; ack = 0; brd = 16'h0F0F;
        issue(0, 16'h0200, 2'd3, 16'h0);
        tick(5);
        chk("R7", "strobe held", rd_n, 0);
        ack = 1;
        tick(4);

        scen = "R10 request while busy";
        wcfg = 3;
        issue(0, 16'h0100, 2'd0, 16'h0);
        issue(1, 16'h0300, 2'd1, 16'h5555);
        tick(8);
        chk("R10", "address kept", baddr, 16'h0100);

        scen = "R3 suspend idle";
        @(negedge clk); susp = 1;
        tick(2);
        chk("R1", "still driven", oe, 1);
        tick(1);
        chk("R1", "floated", oe, 0);
        tick(3);
        chk("R3", "no halt idle", halt, 0);
        susp = 0;
        tick(4);

        scen = "R3 request under suspend";
        susp = 1; tick(4);
        wcfg = 1; brd = 16'h7777;
        issue(0, 16'h0444, 2'd2, 16'h0);
        tick(1);
        chk("R3", "halt raised", halt, 1);
        tick(3);
        susp = 0;
        tick(8);

        scen = "R2 R5 suspend in strobe";
        wcfg = 2; ack = 1; brd = 16'h2468;
        issue(0, 16'h0500, 2'd1, 16'h0);
        susp = 1;
        tick(5);
        chk("R2", "no completion", rdata, 16'h7777);
        susp = 0;
        strb_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!rd_n) strb_cnt++;
        end
        chk("R5", "strobe cycles after resume", strb_cnt, 3);
        chk("R6", "read after resume", rdata, 16'h2468);

        scen = "R4 suspend in address phase";
        wcfg = 0;
        @(negedge clk); susp = 1;
        issue(1, 16'h0606, 2'd3, 16'hC0DE);
        tick(4);
        susp = 0;
        tick(6);

        scen = "R8 suspend during reset";
        susp = 1; tick(4);
        rst_n = 0; tick(3);
        chk("R8", "floated in reset", oe, 0);
        susp = 0; tick(4);
        chk("R8", "driven in reset", oe, 1);
        rst_n = 1; tick(3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule